// File: doc/BRIEF.md
# Stereo Receive Sample Buffer with Channel Pairing

This block holds incoming stereo audio on its way to a processor. The audio side delivers one left and one right 32-bit sample together, once per sample period. Each sample goes into its own channel queue. The processor drains the queues through two independent read strobes, one per channel, and each read takes a full 32-bit word. The processor may empty the channels in any order. It can read a run of left samples and then a run of right samples, do the reverse, or alternate one at a time.

The two queues are managed as a pair and report three conditions. The full indication is live and rises only when both queues hold their maximum. The error flag records any real overflow or underflow on either channel. The resync flag records that the hardware found the channels out of step and realigned them. Realignment happens at a sample-pair push when the two fill levels differ by more than a set skew limit: both queues are emptied and then receive the incoming pair. The error and resync flags stay set until the processor writes a one to the matching clear input.

Top module: `stereo_rx_fifo_pair`

## Requirements
- R1: After reset both queues are empty, `pair_full`, `xrun_flag` and `resync_flag` are 0, and both read data ports show 0.
- R2: Each channel returns its samples in push order. A pair push writes `in_left` to the left queue and `in_right` to the right queue. Each queue holds DEPTH (default 8) words. The read data port shows the oldest word combinationally, and a read strobe removes it at the clock edge.
- R3: `pair_full` is 1 exactly when both queues hold DEPTH words. It is 0 when only one of them does.
- R4: A push into a queue that is full and not being read in the same cycle drops that channel's new sample. The next clock edge sets `xrun_flag`.
- R5: A read strobe on an empty queue shows 0 on that channel's data port. The next clock edge sets `xrun_flag`.
- R6: `xrun_flag` and `resync_flag` hold until a cycle with their clear input at 1. A new event in that same cycle keeps the flag at 1.
- R7: A pair push while the fill levels differ by more than SKEW_LIMIT (default 1) empties both queues and stores the pushed pair as their only entries. The next clock edge sets `resync_flag`.
- R8: If no push falls between the reads, draining N stored pairs in any channel order (left block then right, right block then left, or interleaved) returns every sample and sets neither flag.
- R9: A push and a read on a full queue in the same cycle store the new sample with no overflow.
- R10: In a realignment cycle, read strobes remove nothing and raise no underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_pair | input | 1 | Push one stereo sample pair this cycle |
| in_left | input | WIDTH | Left sample for the push |
| in_right | input | WIDTH | Right sample for the push |
| rd_left | input | 1 | Processor read strobe, left channel |
| rd_right | input | 1 | Processor read strobe, right channel |
| left_word | output | WIDTH | Oldest left word, 0 when the queue is empty |
| right_word | output | WIDTH | Oldest right word, 0 when the queue is empty |
| pair_full | output | 1 | Both queues hold DEPTH words |
| xrun_flag | output | 1 | Sticky overflow/underflow on either channel |
| resync_flag | output | 1 | Sticky channel realignment indication |
| clr_xrun | input | 1 | Write-one-to-clear for `xrun_flag` |
| clr_resync | input | 1 | Write-one-to-clear for `resync_flag` |

## Verification
A pointer or count that slips inside one queue shows up at that channel's data port on the very next read, as a wrong or repeated word. It can also trip `pair_full` or `xrun_flag` one edge early or one edge late. If the level comparison is wrong, the next push triggers a spurious realignment, or misses a needed one, and the flag appears on the edge after that push. Stale words then reach the next reads. The scoreboard compares every read word with its own queues and checks all three flags on every cycle, so such faults are seen within one cycle of the stimulus that exposes them.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;
   localparam int CH_LEFT  = 0;
   localparam int CH_RIGHT = 1;
   localparam int N_CH     = 2;

   typedef enum logic [1:0] {
      EV_NONE  = 2'b00,
      EV_OVER  = 2'b01,
      EV_UNDER = 2'b10
   } xrun_ev_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/srx_chan_fifo.sv
module srx_chan_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head_data,
   output logic [LVL_W-1:0] level,
   output stereo_rx_pkg::xrun_ev_t ev
);
   import stereo_rx_pkg::*;

   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("srx_chan_fifo: DEPTH must be a power of two");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("srx_chan_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             is_empty, is_full, take, keep;

   assign is_empty = (level == '0);
   assign is_full  = (level == LVL_MAX);
   assign take     = pop && !is_empty && !flush;
   assign keep     = push && (flush || !is_full || take);

   always_comb begin
      ev = EV_NONE;
      if (!flush) begin
         if (pop && is_empty)
            ev = EV_UNDER;
         else if (push && is_full && !pop)
            ev = EV_OVER;
      end
   end

   assign head_data = is_empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= push ? PTR_W'(1) : '0;
         level  <= push ? LVL_W'(1) : '0;
      end else begin
         if (take) rd_ptr <= rd_ptr + 1'b1;
         if (keep) wr_ptr <= wr_ptr + 1'b1;
         level <= level + LVL_W'(keep) - LVL_W'(take);
      end
   end

   always_ff @(posedge clk) begin
      if (flush && push)
         mem[0] <= push_data;
      else if (keep)
         mem[wr_ptr] <= push_data;
   end

   p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_MAX);
   p_flush_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> level <= LVL_W'(1));
   p_under_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_UNDER && !push) |=> level == '0);
endmodule

// File: rtl/srx_skew_guard.sv
module srx_skew_guard #(
   parameter int LVL_W      = 4,
   parameter int SKEW_LIMIT = 1
) (
   input  logic             push,
   input  logic [LVL_W-1:0] lvl_a,
   input  logic [LVL_W-1:0] lvl_b,
   output logic             realign
);
   if (SKEW_LIMIT < 0) begin : g_bad_skew
      $error("srx_skew_guard: SKEW_LIMIT must not be negative");
   end

   logic [LVL_W-1:0] gap;
   assign gap     = (lvl_a > lvl_b) ? (lvl_a - lvl_b) : (lvl_b - lvl_a);
   assign realign = push && (gap > LVL_W'(SKEW_LIMIT));
endmodule

// File: rtl/srx_sticky_flag.sv
module srx_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);
endmodule

// File: rtl/stereo_rx_fifo_pair.sv
module stereo_rx_fifo_pair #(
   parameter int WIDTH      = 32,
   parameter int DEPTH      = 8,
   parameter int SKEW_LIMIT = 1,
   localparam int LVL_W     = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_pair,
   input  logic [WIDTH-1:0] in_left,
   input  logic [WIDTH-1:0] in_right,
   input  logic             rd_left,
   input  logic             rd_right,
   output logic [WIDTH-1:0] left_word,
   output logic [WIDTH-1:0] right_word,
   output logic             pair_full,
   output logic             xrun_flag,
   output logic             resync_flag,
   input  logic             clr_xrun,
   input  logic             clr_resync
);
   import stereo_rx_pkg::*;

   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("stereo_rx_fifo_pair: DEPTH must be at least 2");
   end
   if (SKEW_LIMIT >= DEPTH) begin : g_bad_skew
      $error("stereo_rx_fifo_pair: SKEW_LIMIT must be below DEPTH");
   end

   logic [WIDTH-1:0] wr_data [N_CH];
   logic [WIDTH-1:0] rd_data [N_CH];
   logic             rd_strobe [N_CH];
   logic [LVL_W-1:0] lvl [N_CH];
   xrun_ev_t         ev [N_CH];
   logic [N_CH-1:0]  ch_full, ch_err, ch_over;
   logic             realign;

   assign wr_data[CH_LEFT]    = in_left;
   assign wr_data[CH_RIGHT]   = in_right;
   assign rd_strobe[CH_LEFT]  = rd_left;
   assign rd_strobe[CH_RIGHT] = rd_right;

   srx_skew_guard #(.LVL_W(LVL_W), .SKEW_LIMIT(SKEW_LIMIT)) u_skew (
      .push    (push_pair),
      .lvl_a   (lvl[CH_LEFT]),
      .lvl_b   (lvl[CH_RIGHT]),
      .realign (realign)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      srx_chan_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (realign),
         .push      (push_pair),
         .push_data (wr_data[c]),
         .pop       (rd_strobe[c]),
         .head_data (rd_data[c]),
         .level     (lvl[c]),
         .ev        (ev[c])
      );
      assign ch_full[c] = (lvl[c] == LVL_MAX);
      assign ch_err[c]  = (ev[c] != EV_NONE);
      assign ch_over[c] = (ev[c] == EV_OVER);
   end

   assign left_word  = rd_data[CH_LEFT];
   assign right_word = rd_data[CH_RIGHT];
   assign pair_full  = &ch_full;

   srx_sticky_flag u_xrun (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (|ch_err),
      .clr   (clr_xrun),
      .q     (xrun_flag)
   );

   srx_sticky_flag u_resync (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (realign),
      .clr   (clr_resync),
      .q     (resync_flag)
   );

   p_full_needs_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pair_full) |-> $past(push_pair));
   p_over_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_over) |=> xrun_flag);
   p_realign_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      realign |=> resync_flag);
   p_realign_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
      realign |=> (lvl[CH_LEFT] == lvl[CH_RIGHT]));
   p_realign_no_under_r10: assert property (@(posedge clk) disable iff (!rst_n)
      realign |-> !(|ch_err));
endmodule

// File: tb/stereo_rx_fifo_pair_tb.sv
module stereo_rx_fifo_pair_tb;
   localparam int W = 32;
   localparam int D = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         push_pair = 1'b0, rd_left = 1'b0, rd_right = 1'b0;
   logic         clr_xrun = 1'b0, clr_resync = 1'b0;
   logic [W-1:0] in_left = '0, in_right = '0;
   logic [W-1:0] left_word, right_word;
   logic         pair_full, xrun_flag, resync_flag;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [W-1:0] q_l[$];
   logic [W-1:0] q_r[$];
   bit exp_xrun = 0, exp_resync = 0;

   always #10 clk = ~clk;

   stereo_rx_fifo_pair u_dut (
      .clk(clk), .rst_n(rst_n), .push_pair(push_pair),
      .in_left(in_left), .in_right(in_right),
      .rd_left(rd_left), .rd_right(rd_right),
      .left_word(left_word), .right_word(right_word),
      .pair_full(pair_full), .xrun_flag(xrun_flag), .resync_flag(resync_flag),
      .clr_xrun(clr_xrun), .clr_resync(clr_resync)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_flags(input string tag);
      check({tag, " pair_full"}, W'(pair_full), W'((q_l.size() == D) && (q_r.size() == D)));
      check({tag, " xrun_flag"}, W'(xrun_flag), W'(exp_xrun));
      check({tag, " resync_flag"}, W'(resync_flag), W'(exp_resync));
   endtask

   // driver: applies one cycle, updates the scoreboard, monitor compares read words
   task automatic cycle(input string tag, input bit p, input logic [W-1:0] l,
                        input logic [W-1:0] r, input bit rl, input bit rr,
                        input bit cx = 0, input bit cs = 0);
      bit re, err;
      @(negedge clk);
      check_flags(tag);
      push_pair = p; in_left = l; in_right = r;
      rd_left = rl; rd_right = rr; clr_xrun = cx; clr_resync = cs;
      #1;
      if (rl) check({tag, " left_word"}, left_word, (q_l.size() > 0) ? q_l[0] : '0);
      if (rr) check({tag, " right_word"}, right_word, (q_r.size() > 0) ? q_r[0] : '0);
      re = p && ((q_l.size() > q_r.size() + 1) || (q_r.size() > q_l.size() + 1));
      err = 0;
      if (re) begin
         q_l.delete(); q_r.delete();
         q_l.push_back(l); q_r.push_back(r);
      end else begin
         if (rl && q_l.size() == 0) err = 1;
         if (rr && q_r.size() == 0) err = 1;
         if (p && q_l.size() == D && !rl) err = 1;
         if (p && q_r.size() == D && !rr) err = 1;
         if (rl && q_l.size() > 0) void'(q_l.pop_front());
         if (rr && q_r.size() > 0) void'(q_r.pop_front());
         if (p && q_l.size() < D) q_l.push_back(l);
         if (p && q_r.size() < D) q_r.push_back(r);
      end
      exp_xrun   = err ? 1'b1 : (cx ? 1'b0 : exp_xrun);
      exp_resync = re  ? 1'b1 : (cs ? 1'b0 : exp_resync);
      @(posedge clk);
   endtask

   task automatic idle(input string tag);
      cycle(tag, 0, '0, '0, 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 left_word", left_word, '0);
      check("R1 right_word", right_word, '0);
      check_flags("R1");
      rst_n = 1'b1;
      idle("R1");

      // R2 / R8: interleaved drain
      for (int i = 0; i < 3; i++) cycle("R2", 1, 32'h1000 + i, 32'h2000 + i, 0, 0);
      for (int i = 0; i < 3; i++) begin
         cycle("R8 interleave", 0, '0, '0, 1, 0);
         cycle("R8 interleave", 0, '0, '0, 0, 1);
      end
      // R8: left block then right block
      for (int i = 0; i < 3; i++) cycle("R8", 1, 32'h3000 + i, 32'h4000 + i, 0, 0);
      for (int i = 0; i < 3; i++) cycle("R8 left block", 0, '0, '0, 1, 0);
      for (int i = 0; i < 3; i++) cycle("R8 right block", 0, '0, '0, 0, 1);
      // R8: right block then left block
      for (int i = 0; i < 2; i++) cycle("R8", 1, 32'h3100 + i, 32'h4100 + i, 0, 0);
      for (int i = 0; i < 2; i++) cycle("R8 right first", 0, '0, '0, 0, 1);
      for (int i = 0; i < 2; i++) cycle("R8 left after", 0, '0, '0, 1, 0);
      idle("R8 no flags");

      // R3: fill to depth
      for (int i = 0; i < D; i++) cycle("R3 fill", 1, 32'h5000 + i, 32'h6000 + i, 0, 0);
      idle("R3 both full");
      cycle("R9 push+read on full", 1, 32'h5100, 32'h6100, 1, 1);
      idle("R9 still full");
      // R4: overrun on both channels
      cycle("R4 overrun", 1, 32'hDEAD0000, 32'hDEAD0001, 0, 0);
      idle("R4 flag set");
      cycle("R6 clear", 0, '0, '0, 0, 0, 1, 0);
      idle("R6 cleared");
      cycle("R3 one side", 0, '0, '0, 1, 0);
      idle("R3 left not full");
      cycle("R3 realign", 0, '0, '0, 0, 1);
      for (int i = 0; i < D - 1; i++) cycle("R2 drain", 0, '0, '0, 1, 1);
      // R5: underrun on empty left
      cycle("R5 underrun", 0, '0, '0, 1, 0);
      idle("R5 flag set");
      // R6: set and clear in the same cycle keeps flag set
      cycle("R6 set wins", 0, '0, '0, 0, 1, 1, 0);
      idle("R6 still set");
      cycle("R6 clear", 0, '0, '0, 0, 0, 1, 0);
      idle("R6 cleared");

      // R7: skew beyond limit triggers realignment
      for (int i = 0; i < 4; i++) cycle("R7 load", 1, 32'h7000 + i, 32'h8000 + i, 0, 0);
      cycle("R7 skew", 0, '0, '0, 1, 0);
      cycle("R7 skew", 0, '0, '0, 1, 0);
      cycle("R10 realign with reads", 1, 32'h7700, 32'h8800, 1, 1);
      idle("R7 flag set");
      cycle("R7 new pair", 0, '0, '0, 1, 1);
      idle("R7 empty");
      cycle("R6 clear resync", 0, '0, '0, 0, 0, 0, 1);
      idle("R6 resync cleared");
      // R7: skew of exactly the limit does not realign
      cycle("R7 limit", 1, 32'h9000, 32'h9100, 0, 0);
      cycle("R7 limit", 1, 32'h9001, 32'h9101, 0, 0);
      cycle("R7 limit", 0, '0, '0, 1, 0);
      cycle("R7 no realign", 1, 32'h9002, 32'h9102, 0, 0);
      for (int i = 0; i < 3; i++) cycle("R7 drain", 0, '0, '0, 1, 1);
      idle("R7 final");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule